// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable model of a pipelined synchronous static RAM with a shared data path. Each word is 18 bits, held as two 9-bit byte lanes that can be written separately. Every control, address and write-data input is captured in a register on the rising clock edge, and the access runs from those captured values. Read data then passes through an output register. An address presented at edge N therefore produces read data after edge N+1.

A burst of up to four beats can be opened by either of two start strobes. The processor-side strobe always opens a read. The controller-side strobe opens a write when a write is requested, and a read otherwise. On later cycles the advance input steps a two-bit beat counter, which wraps, in linear or XOR (interleaved) order. Leaving advance low holds the burst on its current word. A start strobe sampled while the chip enable is low deselects the device and ends the burst. The output-enable input gates the data drive in the same cycle it changes. The data port is modelled as a separate input, output and drive flag, so a tri-state pad can be attached outside the block.

Top module: `burst_sram`

## Requirements
- R1: While reset is asserted, and after it is released until the first read access, `dataDrive` is 0 and `dataOut` is 0.
- R2: For a read whose inputs are captured at edge N, the word appears on `dataOut` with `dataDrive` high from edge N+1 until the next edge.
- R3: With `writeEn` high, `byteWe[0]` writes lane 0 (bits 8:0) and `byteWe[1]` writes lane 1 (bits 17:9). A lane whose bit is 0 keeps its stored value. With `writeEn` high and `byteWe` 0, no write is requested.
- R4: `allWrite` high writes both lanes, whatever the values of `byteWe` and `writeEn`.
- R5: `procStrobe` with `chipEn` high opens a burst at `addr` and reads that word. The write inputs are ignored on that edge.
- R6: `ctrlStrobe` with `chipEn` high (and `procStrobe` low) opens a burst at `addr`. It writes that word when a write is requested, and reads it otherwise.
- R7: When both strobes are high with `chipEn` high, the processor-side strobe wins: the word is read and nothing is written.
- R8: With `seqMode` = 0, each continue cycle with `advance` high accesses word {base[5:2], (base[1:0]+n) mod 4}, where n is the number of advances since the burst opened.
- R9: With `seqMode` = 1, the continue access goes to {base[5:2], base[1:0] XOR n}.
- R10: A continue cycle with `advance` low accesses the same word as the previous beat (a read repeats it, a write overwrites it).
- R11: `ctrlStrobe` with a write request during a write burst loads the new address and writes it in that cycle, with no idle beat.
- R12: A write cycle leaves `dataDrive` low on the following cycle. Once a burst has written, its continue cycles without a write produce no read output until a new start strobe.
- R13: A start strobe with `chipEn` low ends the burst. `dataDrive` is low on the following cycle, and later continue cycles access nothing.
- R14: `dataDrive` equals the registered read-valid flag ANDed with the present `outEn`. When `dataDrive` is low, `dataOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of control and output state |
| addr | input | ADDR_W | Word address, used on start cycles |
| chipEn | input | 1 | Chip enable, sampled with the start strobes |
| procStrobe | input | 1 | Processor-side burst start, always a read |
| ctrlStrobe | input | 1 | Controller-side burst start, read or write |
| advance | input | 1 | Steps the beat counter on continue cycles |
| byteWe | input | LANES | Per-lane write enables, qualified by writeEn |
| writeEn | input | 1 | Enables the lane writes selected by byteWe |
| allWrite | input | 1 | Writes every lane |
| seqMode | input | 1 | Burst order: 0 linear, 1 XOR |
| outEn | input | 1 | Output enable, applied in the same cycle |
| dataIn | input | LANE_W*LANES | Write data, captured with the command |
| dataOut | output | LANE_W*LANES | Registered read data, 0 when not driving |
| dataDrive | output | 1 | High when the block drives the data bus |

## Verification
The hardest state to reach from the ports is a burst whose beat counter has wrapped part-way through, in either order, after a base that does not start on a four-word boundary. The bench opens write bursts at every base offset from 0 to 7 in both orders. It then reads each word back with single accesses at addresses computed arithmetically from the base and the beat number, so a word written to the wrong place shows up. Suspended, extended and deselected bursts are built in the same way: each is a short, fixed run of continue cycles placed right after a start strobe.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  // Strobes the control issues to the datapath for one access cycle.
  typedef struct packed {
    logic doRead;
    logic doWrite;
  } access_strobe_t;

  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } burst_order_t;

  typedef enum logic [2:0] {
    CY_IDLE,
    CY_DESEL,
    CY_START_P,
    CY_START_C,
    CY_CONT
  } cycle_kind_t;

endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 2,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              chipEn,
  input  logic              procStrobe,
  input  logic              ctrlStrobe,
  input  logic              advance,
  input  logic [LANES-1:0]  byteWe,
  input  logic              writeEn,
  input  logic              allWrite,
  input  logic              seqMode,
  output access_strobe_t    strb,
  output logic [ADDR_W-1:0] accAddr,
  output logic [LANES-1:0]  laneMask
);

  localparam int HIGH_W = ADDR_W - BURST_W;

  // Input capture stage
  logic [ADDR_W-1:0] rAddr;
  logic              rChipEn, rProcStrobe, rCtrlStrobe, rAdvance;
  logic [LANES-1:0]  rByteWe;
  logic              rWriteEn, rAllWrite, rSeqMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rAddr       <= '0;
      rChipEn     <= 1'b0;
      rProcStrobe <= 1'b0;
      rCtrlStrobe <= 1'b0;
      rAdvance    <= 1'b0;
      rByteWe     <= '0;
      rWriteEn    <= 1'b0;
      rAllWrite   <= 1'b0;
      rSeqMode    <= 1'b0;
    end else begin
      rAddr       <= addr;
      rChipEn     <= chipEn;
      rProcStrobe <= procStrobe;
      rCtrlStrobe <= ctrlStrobe;
      rAdvance    <= advance;
      rByteWe     <= byteWe;
      rWriteEn    <= writeEn;
      rAllWrite   <= allWrite;
      rSeqMode    <= seqMode;
    end
  end

  // Burst state
  logic              burstOn;
  logic              burstRead;
  logic [ADDR_W-1:0] baseAddr;
  logic [BURST_W-1:0] beatCnt;

  cycle_kind_t        kind;
  logic               wrReq;
  logic [LANES-1:0]   laneSel;
  logic [BURST_W-1:0] nextCnt;
  logic [BURST_W-1:0] lowLin, lowXor, lowSel;
  logic [HIGH_W-1:0]  highPart;

  always_comb begin
    if ((rProcStrobe || rCtrlStrobe) && !rChipEn) kind = CY_DESEL;
    else if (rProcStrobe)                         kind = CY_START_P;
    else if (rCtrlStrobe)                         kind = CY_START_C;
    else if (burstOn)                             kind = CY_CONT;
    else                                          kind = CY_IDLE;
  end

  assign wrReq   = rAllWrite || (rWriteEn && (|rByteWe));
  assign laneSel = rAllWrite ? {LANES{1'b1}} : (rWriteEn ? rByteWe : '0);
  assign nextCnt = (kind == CY_CONT && rAdvance) ? beatCnt + 1'b1 : beatCnt;

  assign highPart = baseAddr[ADDR_W-1:BURST_W];
  assign lowLin   = baseAddr[BURST_W-1:0] + nextCnt;
  assign lowXor   = baseAddr[BURST_W-1:0] ^ nextCnt;
  assign lowSel   = (burst_order_t'(rSeqMode) == ORDER_XOR) ? lowXor : lowLin;

  always_comb begin
    strb    = '0;
    accAddr = rAddr;
    unique case (kind)
      CY_START_P: strb.doRead = 1'b1;
      CY_START_C: begin
        if (wrReq) strb.doWrite = 1'b1;
        else       strb.doRead  = 1'b1;
      end
      CY_CONT: begin
        accAddr = {highPart, lowSel};
        if (wrReq)          strb.doWrite = 1'b1;
        else if (burstRead) strb.doRead  = 1'b1;
      end
      default: ;
    endcase
  end

  assign laneMask = strb.doWrite ? laneSel : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstOn   <= 1'b0;
      burstRead <= 1'b0;
      baseAddr  <= '0;
      beatCnt   <= '0;
    end else begin
      unique case (kind)
        CY_DESEL: begin
          burstOn   <= 1'b0;
          burstRead <= 1'b0;
        end
        CY_START_P: begin
          burstOn   <= 1'b1;
          burstRead <= 1'b1;
          baseAddr  <= rAddr;
          beatCnt   <= '0;
        end
        CY_START_C: begin
          burstOn   <= 1'b1;
          burstRead <= !wrReq;
          baseAddr  <= rAddr;
          beatCnt   <= '0;
        end
        CY_CONT: begin
          beatCnt <= nextCnt;
          if (wrReq) burstRead <= 1'b0;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/burst_sram_dpath.sv
module burst_sram_dpath
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [LANE_W*LANES-1:0] dataIn,
  input  logic                    outEn,
  input  access_strobe_t          strb,
  input  logic [ADDR_W-1:0]       accAddr,
  input  logic [LANES-1:0]        laneMask,
  output logic [LANE_W*LANES-1:0] dataOut,
  output logic                    dataDrive
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = LANE_W * LANES;

  logic [WORD_W-1:0] rData;
  logic [WORD_W-1:0] outWord;
  logic              outValid;

  // Write data is captured with the command it belongs to.
  always_ff @(posedge clk) rData <= dataIn;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic [LANE_W-1:0] laneQ;

    always_ff @(posedge clk) begin
      if (strb.doWrite && laneMask[g])
        laneMem[accAddr] <= rData[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            laneQ <= '0;
      else if (strb.doRead) laneQ <= laneMem[accAddr];
    end

    assign outWord[g*LANE_W +: LANE_W] = laneQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= strb.doRead;
  end

  assign dataDrive = outValid && outEn;
  assign dataOut   = dataDrive ? outWord : '0;

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANE_W  = 9,
  parameter int LANES   = 2,
  parameter int BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    chipEn,
  input  logic                    procStrobe,
  input  logic                    ctrlStrobe,
  input  logic                    advance,
  input  logic [LANES-1:0]        byteWe,
  input  logic                    writeEn,
  input  logic                    allWrite,
  input  logic                    seqMode,
  input  logic                    outEn,
  input  logic [LANE_W*LANES-1:0] dataIn,
  output logic [LANE_W*LANES-1:0] dataOut,
  output logic                    dataDrive
);

  access_strobe_t    strb;
  logic [ADDR_W-1:0] accAddr;
  logic [LANES-1:0]  laneMask;

  burst_sram_ctrl #(
    .ADDR_W(ADDR_W), .LANES(LANES), .BURST_W(BURST_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .chipEn(chipEn),
    .procStrobe(procStrobe), .ctrlStrobe(ctrlStrobe), .advance(advance),
    .byteWe(byteWe), .writeEn(writeEn), .allWrite(allWrite),
    .seqMode(seqMode), .strb(strb), .accAddr(accAddr), .laneMask(laneMask)
  );

  burst_sram_dpath #(
    .ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .outEn(outEn), .strb(strb),
    .accAddr(accAddr), .laneMask(laneMask), .dataOut(dataOut),
    .dataDrive(dataDrive)
  );

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk (
  input logic clk,
  input logic rstN,
  input logic chipEn,
  input logic procStrobe,
  input logic ctrlStrobe,
  input logic allWrite,
  input logic outEn,
  input logic dataDrive
);

  assert_desel_quiet_R13: assert property (@(posedge clk) disable iff (!rstN)
    ((procStrobe || ctrlStrobe) && !chipEn) |-> ##2 !dataDrive);

  assert_write_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlStrobe && !procStrobe && chipEn && allWrite) |-> ##2 !dataDrive);

  assert_proc_reads_R5: assert property (@(posedge clk) disable iff (!rstN)
    (procStrobe && chipEn) |-> ##2 (dataDrive || !outEn));

  assert_proc_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    (procStrobe && ctrlStrobe && chipEn && allWrite) |-> ##2 (dataDrive || !outEn));

  assert_oe_gates_R14: assert property (@(posedge clk) disable iff (!rstN)
    dataDrive |-> outEn);

endmodule

bind burst_sram burst_sram_chk u_chk (
  .clk(clk), .rstN(rstN), .chipEn(chipEn), .procStrobe(procStrobe),
  .ctrlStrobe(ctrlStrobe), .allWrite(allWrite), .outEn(outEn),
  .dataDrive(dataDrive)
);

// File: tb/sim_burst_sram.sv
module sim_burst_sram;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  addr;
  logic        chipEn, procStrobe, ctrlStrobe, advance;
  logic [1:0]  byteWe;
  logic        writeEn, allWrite, seqMode, outEn;
  logic [17:0] dataIn;
  logic [17:0] dataOut;
  logic        dataDrive;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference model state
  logic [17:0] mem [64];
  bit          mActive, mRead;
  logic [5:0]  mBase;
  logic [1:0]  mCnt;
  bit          pendRd = 0;
  logic [17:0] pendVal = '0;
  string       pendTag = "R1";

  always #10 clk = ~clk;

  burst_sram u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .chipEn(chipEn),
    .procStrobe(procStrobe), .ctrlStrobe(ctrlStrobe), .advance(advance),
    .byteWe(byteWe), .writeEn(writeEn), .allWrite(allWrite),
    .seqMode(seqMode), .outEn(outEn), .dataIn(dataIn),
    .dataOut(dataOut), .dataDrive(dataDrive)
  );

  function automatic logic [17:0] patA(int a);
    return 18'((a * 1031 + 77) & 18'h3FFFF);
  endfunction
  function automatic logic [17:0] patB(int a);
    return 18'((a * 613 + 1234) & 18'h3FFFF);
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [17:0] act, logic [17:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    addr = '0; chipEn = 1'b1; procStrobe = 1'b0; ctrlStrobe = 1'b0;
    advance = 1'b0; byteWe = '0; writeEn = 1'b0; allWrite = 1'b0;
    outEn = 1'b1; dataIn = '0;
  endtask

  // Apply the current inputs for one cycle, update the model, check the
  // output of the previous command one cycle later.
  task automatic step(string tag);
    bit          wr, doRd, doWr;
    logic [1:0]  msk;
    logic [5:0]  a;
    logic [17:0] v;
    bit          expDrive;
    wr   = allWrite || (writeEn && (byteWe != 0));
    msk  = allWrite ? 2'b11 : (writeEn ? byteWe : 2'b00);
    doRd = 0; doWr = 0; a = addr; v = '0;
    if ((procStrobe || ctrlStrobe) && !chipEn) begin
      mActive = 0; mRead = 0;
    end else if (procStrobe) begin
      mBase = addr; mCnt = 0; mActive = 1; mRead = 1; doRd = 1;
    end else if (ctrlStrobe) begin
      mBase = addr; mCnt = 0; mActive = 1;
      if (wr) begin doWr = 1; mRead = 0; end
      else begin doRd = 1; mRead = 1; end
    end else if (mActive) begin
      if (advance) mCnt = mCnt + 2'd1;
      a = {mBase[5:2], seqMode ? (mBase[1:0] ^ mCnt) : (mBase[1:0] + mCnt)};
      if (wr) begin doWr = 1; mRead = 0; end
      else if (mRead) doRd = 1;
    end
    if (doWr) begin
      if (msk[0]) mem[a][8:0]  = dataIn[8:0];
      if (msk[1]) mem[a][17:9] = dataIn[17:9];
    end
    if (doRd) v = mem[a];
    @(posedge clk);
    @(negedge clk);
    expDrive = pendRd && outEn;
    chk(dataDrive === expDrive, pendTag, "drive", 18'(dataDrive), 18'(expDrive));
    chk(dataOut === (expDrive ? pendVal : 18'h0), pendTag, "data", dataOut,
        expDrive ? pendVal : 18'h0);
    pendRd = doRd; pendVal = v; pendTag = tag;
  endtask

  task automatic wrAll(int a, logic [17:0] d, string tag);
    idle(); ctrlStrobe = 1'b1; addr = 6'(a); allWrite = 1'b1; dataIn = d; step(tag);
  endtask
  task automatic wrLane(int a, logic [17:0] d, logic [1:0] m, string tag);
    idle(); ctrlStrobe = 1'b1; addr = 6'(a); writeEn = 1'b1; byteWe = m; dataIn = d; step(tag);
  endtask
  task automatic rdP(int a, string tag);
    // write inputs held active: must be ignored (R5)
    idle(); procStrobe = 1'b1; addr = 6'(a); allWrite = 1'b1; writeEn = 1'b1;
    byteWe = 2'b11; dataIn = 18'h2AAAA; step(tag);
  endtask
  task automatic contB(bit adv, bit w, logic [17:0] d, string tag);
    idle(); advance = adv; allWrite = w; dataIn = d; step(tag);
  endtask
  task automatic desel(string tag);
    idle(); procStrobe = 1'b1; chipEn = 1'b0; step(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(); seqMode = 1'b0;
    mActive = 0; mRead = 0; mBase = '0; mCnt = '0;
    repeat (3) @(negedge clk);
    chk(dataDrive === 1'b0, "R1", "drive in reset", 18'(dataDrive), 18'h0);
    chk(dataOut === 18'h0, "R1", "data in reset", dataOut, 18'h0);
    rstN = 1'b1;
    desel("R1");
    desel("R1");

    // fill: controller-strobe writes (R6), no drive after writes (R12)
    for (int a = 0; a < 64; a++) wrAll(a, patA(a), "R6 R12");
    desel("R12");
    for (int a = 0; a < 64; a++) rdP(a, "R2 R5");
    desel("R2");

    // byte-lane writes, mask = a mod 4
    for (int a = 0; a < 64; a++) wrLane(a, patB(a), 2'(a % 4), "R3");
    desel("R3");
    for (int a = 0; a < 64; a++) rdP(a, "R3");
    desel("R3");

    // global write with lane enables off
    for (int a = 0; a < 16; a++) begin
      idle(); ctrlStrobe = 1'b1; addr = 6'(a); allWrite = 1'b1;
      byteWe = 2'b00; writeEn = 1'b0; dataIn = ~patA(a); step("R4");
    end
    for (int a = 0; a < 16; a++) rdP(a, "R4");
    desel("R4");

    // controller strobe without write request reads
    idle(); ctrlStrobe = 1'b1; addr = 6'd5; step("R6");
    desel("R6");

    // bursts in both orders from every offset
    for (int md = 0; md < 2; md++) begin
      for (int b = 0; b < 8; b++) begin
        int base;
        string t;
        base = 16 + b;
        t = md ? "R9" : "R8";
        seqMode = md[0];
        idle(); seqMode = md[0]; ctrlStrobe = 1'b1; addr = 6'(base);
        allWrite = 1'b1; dataIn = patB(base * 7 + md); step(t);
        for (int k = 1; k < 4; k++) begin
          seqMode = md[0]; contB(1'b1, 1'b1, patB(base * 7 + md + k * 50), t);
        end
        seqMode = md[0]; desel(t);
        for (int k = 0; k < 4; k++) begin
          int wa;
          wa = md ? ((base & ~3) | ((base & 3) ^ k)) : ((base & ~3) | (((base & 3) + k) & 3));
          rdP(wa, t);
          chk(mem[wa] === patB(base * 7 + md + k * 50), t, "model order",
              mem[wa], patB(base * 7 + md + k * 50));
        end
        seqMode = md[0]; rdP(base, t);
        for (int k = 1; k < 5; k++) begin
          seqMode = md[0]; contB(1'b1, 1'b0, '0, t);
        end
        seqMode = md[0]; desel(t);
      end
    end
    seqMode = 1'b0;

    // suspended burst
    rdP(33, "R10");
    contB(1'b0, 1'b0, '0, "R10");
    contB(1'b0, 1'b0, '0, "R10");
    contB(1'b1, 1'b0, '0, "R10");
    contB(1'b0, 1'b0, '0, "R10");
    contB(1'b1, 1'b0, '0, "R10");
    desel("R10");
    wrAll(36, 18'h11111, "R10");
    contB(1'b0, 1'b1, 18'h22222, "R10");
    contB(1'b1, 1'b1, 18'h33333, "R10");
    desel("R10");
    rdP(36, "R10"); rdP(37, "R10"); desel("R10");

    // extended write burst
    wrAll(40, 18'h0F0F0, "R11");
    contB(1'b1, 1'b1, 18'h1E1E1, "R11");
    wrAll(50, 18'h2D2D2, "R11");
    contB(1'b1, 1'b1, 18'h3C3C3, "R11");
    desel("R11");
    rdP(40, "R11"); rdP(41, "R11"); rdP(50, "R11"); rdP(51, "R11"); rdP(42, "R11");
    desel("R11");

    // both strobes: read wins
    idle(); procStrobe = 1'b1; ctrlStrobe = 1'b1; addr = 6'd9; allWrite = 1'b1;
    dataIn = 18'h15555; step("R7");
    desel("R7");
    rdP(9, "R7"); desel("R7");

    // write inside a read burst silences later beats
    rdP(44, "R12");
    contB(1'b1, 1'b1, 18'h0ABCD, "R12");
    contB(1'b1, 1'b0, '0, "R12");
    contB(1'b1, 1'b0, '0, "R12");
    desel("R12");
    rdP(45, "R12"); desel("R12");

    // deselect ends burst
    rdP(56, "R13");
    contB(1'b1, 1'b0, '0, "R13");
    desel("R13");
    contB(1'b1, 1'b0, '0, "R13");
    contB(1'b1, 1'b0, '0, "R13");
    rdP(57, "R13");
    desel("R13");

    // output enable gates drive in the same cycle
    rdP(12, "R14");
    idle(); procStrobe = 1'b1; chipEn = 1'b0; outEn = 1'b0; step("R14");
    rdP(13, "R14");
    desel("R14");
    desel("R14");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule